// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Converter Code Registers

This block holds the digital codes for a pair of 12-bit converter channels that are written over an 8-bit bus. Each channel has two input registers: an 8-bit low register for code bits 7..0 and a 4-bit high register for code bits 11..8. The two input registers together feed a 12-bit output register, and that register drives the channel's code.

A host writes the four input registers one at a time. It then moves both channels to their outputs together with a shared update strobe, so that both output codes change in the same clock cycle. If the host asserts select, update and write together, the output registers become transparent: the byte written in that cycle reaches the output at the same clock edge.

An active-low clear zeroes every register at once and overrides all other inputs. All other controls are levels sampled on the rising clock edge.

Top module: `dual_dac_regs`

## Requirements
- R1: While `clearN` is low, both `codeA` and `codeB` read zero, with no clock edge needed. This includes the time before the first clock edge.
- R2: A write with `selN`=0, `writeN`=0 and `updateN`=1 loads only the input register chosen by `addr`. Neither output code changes.
- R3: The register `addr` selects as follows: 0 is the channel A low register, 1 is the channel A high register, 2 is the channel B low register and 3 is the channel B high register. A low register takes `busData[7:0]` as code bits 7..0. A high register takes `busData[3:0]` as code bits 11..8 and ignores `busData[7:4]`.
- R4: With `selN`=1, `writeN`=0 and `updateN`=0, both output registers copy their input registers at the same clock edge, whatever the value of `addr`.
- R5: When `writeN` is 1, or when `selN` and `updateN` are both 1, no input register and no output register changes.
- R6: With `selN`, `writeN` and `updateN` all low, the addressed input register loads. At the same edge, both output registers take their full input values, including the byte written in that cycle.
- R7: Clear zeroes the input registers as well as the output registers, and it wins over any write or update held during it.
- R8: After `clearN` rises, the design ignores commands on the first two rising edges. It acts on the third edge.
- R9: Output codes change only on a rising clock edge or when clear is asserted.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; controls are sampled on its rising edge |
| clearN | input | 1 | Active-low clear; asserts asynchronously and releases synchronously |
| selN | input | 1 | Active-low select for input-register writes |
| writeN | input | 1 | Active-low write strobe |
| updateN | input | 1 | Active-low output-register update |
| addr | input | 2 | Input-register select: bit 1 picks the channel, bit 0 picks the high register |
| busData | input | 8 | Write data bus |
| codeA | output | 12 | Channel A output code |
| codeB | output | 12 | Channel B output code |

## Verification
The assertions assume that the control inputs and `clearN` change away from the rising clock edge. They also assume that the internal release of clear, not the raw pin, marks the start of normal operation. The stimulus meets both conditions: it drives every input on the falling edge, and it asserts clear only between edges. During the two-edge release window it holds commands on purpose, and it checks the outputs rather than relying on properties there. Transparent writes and plain updates are mixed with idle and blocked-command cycles, so that every property sees each side of its condition.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;
  localparam int LO_W   = 8;
  localparam int HI_W   = 4;
  localparam int CODE_W = LO_W + HI_W;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = $clog2(NUM_CH) + 1;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] loadLo;
    logic [NUM_CH-1:0] loadHi;
    logic              copyOut;
    logic              passThru;
  } strobe_t;
endpackage

// File: rtl/dac_regs_ctrl.sv
module dac_regs_ctrl
  import dac_regs_pkg::*;
(
  input  logic              clk,
  input  logic              clearN,
  input  logic              selN,
  input  logic              writeN,
  input  logic              updateN,
  input  logic [ADDR_W-1:0] addr,
  output logic              regRstN,
  output strobe_t           strobes
);
  logic [SYNC_STAGES-1:0] relSync;
  logic [ADDR_W-2:0]      chSel;

  // asynchronous assert, synchronous release of the register reset
  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN) relSync <= '0;
    else         relSync <= {relSync[SYNC_STAGES-2:0], 1'b1};
  end

  assign regRstN = relSync[SYNC_STAGES-1];
  assign chSel   = addr[ADDR_W-1:1];

  always_comb begin
    strobes = '0;
    if (!writeN) begin
      if (!selN) begin
        if (addr[0]) strobes.loadHi[chSel] = 1'b1;
        else         strobes.loadLo[chSel] = 1'b1;
      end
      if (!updateN) begin
        if (selN) strobes.copyOut  = 1'b1;
        else      strobes.passThru = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_regs_datapath.sv
module dac_regs_datapath
  import dac_regs_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strobes,
  input  logic [LO_W-1:0]                busData,
  output logic [NUM_CH-1:0][CODE_W-1:0]  codes
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [LO_W-1:0]   loReg, loNext;
    logic [HI_W-1:0]   hiReg, hiNext;
    logic [CODE_W-1:0] outReg;

    assign loNext = strobes.loadLo[g] ? busData           : loReg;
    assign hiNext = strobes.loadHi[g] ? busData[HI_W-1:0] : hiReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loReg  <= '0;
        hiReg  <= '0;
        outReg <= '0;
      end else begin
        loReg <= loNext;
        hiReg <= hiNext;
        if (strobes.passThru)     outReg <= {hiNext, loNext};
        else if (strobes.copyOut) outReg <= {hiReg, loReg};
      end
    end

    assign codes[g] = outReg;
  end
endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
  import dac_regs_pkg::*;
(
  input  logic              clk,
  input  logic              clearN,
  input  logic              selN,
  input  logic              writeN,
  input  logic              updateN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LO_W-1:0]   busData,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB
);
  strobe_t                       strobes;
  logic                          regRstN;
  logic [NUM_CH-1:0][CODE_W-1:0] codes;

  dac_regs_ctrl u_ctrl (
    .clk     (clk),
    .clearN  (clearN),
    .selN    (selN),
    .writeN  (writeN),
    .updateN (updateN),
    .addr    (addr),
    .regRstN (regRstN),
    .strobes (strobes)
  );

  dac_regs_datapath u_dp (
    .clk     (clk),
    .rstN    (regRstN),
    .strobes (strobes),
    .busData (busData),
    .codes   (codes)
  );

  assign codeA = codes[0];
  assign codeB = codes[1];
endmodule

// File: rtl/dual_dac_regs_chk.sv
module dual_dac_regs_chk
  import dac_regs_pkg::*;
(
  input logic              clk,
  input logic              clearN,
  input logic              regRstN,
  input logic              selN,
  input logic              writeN,
  input logic              updateN,
  input logic [ADDR_W-1:0] addr,
  input logic [LO_W-1:0]   busData,
  input logic [CODE_W-1:0] codeA,
  input logic [CODE_W-1:0] codeB
);
  p_clear_zero_r1: assert property (@(posedge clk)
    !clearN |-> (codeA == '0 && codeB == '0));

  p_load_only_r2: assert property (@(posedge clk) disable iff (!regRstN)
    (!selN && !writeN && updateN) |=> ($stable(codeA) && $stable(codeB)));

  p_write_idle_r5: assert property (@(posedge clk) disable iff (!regRstN)
    writeN |=> ($stable(codeA) && $stable(codeB)));

  p_desel_idle_r5: assert property (@(posedge clk) disable iff (!regRstN)
    (selN && updateN) |=> ($stable(codeA) && $stable(codeB)));

  p_pass_lo_a_r6: assert property (@(posedge clk) disable iff (!regRstN)
    (!selN && !writeN && !updateN && addr == 2'b00)
      |=> codeA[LO_W-1:0] == $past(busData));

  p_pass_hi_b_r6: assert property (@(posedge clk) disable iff (!regRstN)
    (!selN && !writeN && !updateN && addr == 2'b11)
      |=> codeB[CODE_W-1:LO_W] == $past(busData[HI_W-1:0]));
endmodule

bind dual_dac_regs dual_dac_regs_chk u_chk (
  .clk     (clk),
  .clearN  (clearN),
  .regRstN (regRstN),
  .selN    (selN),
  .writeN  (writeN),
  .updateN (updateN),
  .addr    (addr),
  .busData (busData),
  .codeA   (codeA),
  .codeB   (codeB)
);

// File: tb/dual_dac_regs_test.sv
`timescale 1ns/1ps
module dual_dac_regs_test;
  logic        clk = 1'b0;
  logic        clearN = 1'b0;
  logic        selN = 1'b1, writeN = 1'b1, updateN = 1'b1;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  busData = 8'h00;
  logic [11:0] codeA, codeB;
  int          checks = 0, fails = 0;

  always #2 clk = ~clk;

  dual_dac_regs uut (
    .clk(clk), .clearN(clearN), .selN(selN), .writeN(writeN),
    .updateN(updateN), .addr(addr), .busData(busData),
    .codeA(codeA), .codeB(codeB)
  );

  task automatic check(input string req, input logic [11:0] expA, input logic [11:0] expB);
    checks++;
    if (codeA !== expA || codeB !== expB) begin
      fails++;
      $display("FAIL %s: codeA=%h codeB=%h expected codeA=%h codeB=%h",
               req, codeA, codeB, expA, expB);
    end
  endtask

  task automatic idle();
    selN = 1'b1; writeN = 1'b1; updateN = 1'b1;
  endtask

  // drive on a falling edge, let one rising edge pass, return on the next falling edge
  task automatic cycle(input logic s, input logic w, input logic u,
                       input logic [1:0] a, input logic [7:0] d);
    selN = s; writeN = w; updateN = u; addr = a; busData = d;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    #1 check("R1 before first edge", 12'h000, 12'h000);
    @(negedge clk); @(negedge clk);
    check("R1 held clear", 12'h000, 12'h000);
    clearN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_load_only();
    cycle(0, 0, 1, 2'b00, 8'hA5);
    check("R2 after A low", 12'h000, 12'h000);
    cycle(0, 0, 1, 2'b01, 8'h3C);
    cycle(0, 0, 1, 2'b10, 8'h5A);
    cycle(0, 0, 1, 2'b11, 8'hF7);
    check("R2 after four loads", 12'h000, 12'h000);
  endtask

  task automatic t_update();
    cycle(1, 0, 0, 2'b10, 8'hFF);
    check("R4/R3 joint update", 12'hCA5, 12'h75A);
  endtask

  task automatic t_hold();
    cycle(0, 1, 0, 2'b00, 8'h11);
    check("R5 write high", 12'hCA5, 12'h75A);
    cycle(1, 0, 1, 2'b11, 8'h22);
    check("R5 select and update high", 12'hCA5, 12'h75A);
    cycle(1, 0, 0, 2'b01, 8'h33);
    check("R5 input regs untouched", 12'hCA5, 12'h75A);
  endtask

  task automatic t_transparent();
    cycle(0, 0, 0, 2'b01, 8'hE9);
    check("R6 same-cycle high nibble A", 12'h9A5, 12'h75A);
    cycle(0, 0, 0, 2'b10, 8'h11);
    check("R6 same-cycle low byte B", 12'h9A5, 12'h711);
    @(negedge clk);
    check("R9 no edge activity", 12'h9A5, 12'h711);
  endtask

  task automatic t_clear();
    selN = 0; writeN = 0; updateN = 0; addr = 2'b00; busData = 8'h66;
    #0.5 clearN = 1'b0;
    #0.5 check("R1 immediate clear", 12'h000, 12'h000);
    @(negedge clk);
    check("R7 clear beats transparent write", 12'h000, 12'h000);
    clearN = 1'b1;
    @(negedge clk);
    check("R8 first edge after release", 12'h000, 12'h000);
    @(negedge clk);
    check("R8 second edge after release", 12'h000, 12'h000);
    @(negedge clk);
    idle();
    check("R8/R7 third edge acts, inputs were cleared", 12'h066, 12'h000);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_load_only();
    t_update();
    t_hold();
    t_transparent();
    t_clear();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule